// File: doc/BRIEF.md
# SPI Write-Then-Read Master Controller

This block is a register-mapped SPI master. One transaction consists of a write phase and, optionally, a read phase. A single trigger starts the transaction, and the read phase follows the write phase with chip select held low the whole time. Software does four things:

- It programs a byte-rate divisor.
- It programs a transfer descriptor: the mode, plus the write and read byte counts, each stored as the count minus one.
- It pushes the first transmit word into the shared 32-bit data port.
- It sets the trigger bit. It then keeps feeding transmit words and drains received words through the same data port.

Four-word FIFOs sit behind the data port in both directions. Bytes are packed into words least significant byte first. On the wire each byte goes out most significant bit first, in clock mode 0 with an active-low select.

Registers are selected by a 3-bit word address:

| Address | Register |
|---|---|
| 0 | control |
| 1 | divisor |
| 2 | descriptor |
| 3 | status |
| 4 | interrupt enable |
| 5 | data |

A write takes effect on the clock edge where `bus_wr` is high. Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `spi_wr_master`

## Requirements
- R1: The divisor register (address 1) holds the baud value B in bits [7:0]. Bits [31:8] are stored and read back unchanged. Each high and each low half of SCLK inside a byte lasts exactly B+1 bus clocks.
- R2: The descriptor (address 2) has these fields:
  - bit 0: mode, 0 for write-only and 1 for write-then-read.
  - bits [15:8]: write byte count minus one.
  - bits [23:16]: read byte count minus one.
  - bit 31: trigger.

  A transaction clocks exactly the write count of bytes, plus the read count in mode 1, during a single low period of `spi_cs_n`. On readback, bit 31 shows busy.
- R3: Writing the descriptor with bit 31 set while idle starts a transaction. From the next status read, status bit 0 (busy) stays 1 until the transaction ends. Descriptor writes made while busy are ignored.
- R4: Status bit 1 (TX full) is 1 when four words are queued for transmit. A data write made while TX full is dropped.
- R5: Write-phase bytes are taken from each data word starting with the least significant byte. Each byte is shifted out MSB first on `spi_mosi`, which changes only while SCLK is low.
- R6: MISO is sampled on the rising SCLK edge. Only read-phase bytes are stored, packed least significant byte first. A partial final word has zero upper bytes.
- R7: `spi_mosi` is low throughout the read phase.
- R8: Reading the data register while the receive FIFO is empty returns 0 and changes nothing. Status bit 2 is 1 whenever received data is waiting.
- R9: `spi_cs_n` falls exactly B+1 clocks before the first rising SCLK edge. It rises no sooner than B+1 clocks after the last falling edge. SCLK is low whenever `spi_cs_n` is high.
- R10: Writing 1 to control bit 0 aborts any transaction and returns the controller to idle. It also empties both FIFOs. The divisor and interrupt-enable registers keep their values.
- R11: After reset the following hold:
  - `spi_cs_n` is 1, and SCLK and MOSI are 0.
  - The status, descriptor and interrupt-enable registers read 0.
  - The interrupt-enable register (address 4) stores and returns all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Most internal faults show on the wire. A wrong byte counter or phase flag gives the wrong number of bytes under one select pulse. It can also leave MOSI driven during the read phase, or shift received bytes into the wrong word lanes. All of these are visible at the end of the transaction.

A bad divisor counter changes the measured SCLK half widths on the very first bit.

FIFO faults show on the bus side instead. Broken full or empty logic leaves a stale or duplicated word. That word surfaces on MOSI in the next transaction, or as a nonzero value from an empty data read.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_DIV  = 3'd1,
    RA_DESC = 3'd2,
    RA_STAT = 3'd3,
    RA_IEN  = 3'd4,
    RA_DATA = 3'd5
  } reg_addr_e;

  typedef enum logic [2:0] {
    ES_IDLE,
    ES_FETCH,
    ES_LOW,
    ES_HIGH,
    ES_PUSH,
    ES_TRAIL
  } eng_state_e;

  // descriptor field positions
  localparam int DESC_MODE_BIT = 0;
  localparam int DESC_WCNT_LSB = 8;
  localparam int DESC_RCNT_LSB = 16;
  localparam int DESC_GO_BIT   = 31;

  // status bit positions
  localparam int STAT_BUSY    = 0;
  localparam int STAT_TXFULL  = 1;
  localparam int STAT_RXAVAIL = 2;
endpackage

// File: rtl/spi_wr_fifo.sv
module spi_wr_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   LVL_MAX = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      level;
  logic             do_push, do_pop;

  assign full    = (level == LVL_MAX);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= (wp == PTR_MAX) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PTR_MAX) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R4: the owner never offers a word to a full queue
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R8: the owner never pops an empty queue
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_MAX);
endmodule

// File: rtl/spi_wr_engine.sv
module spi_wr_engine
  import spi_wr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int BAUD_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_wr,
  input  logic [CNT_W-1:0]  wcnt_m1,
  input  logic [CNT_W-1:0]  rcnt_m1,
  input  logic [BAUD_W-1:0] baud,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);
  localparam int BYTES = WORD_W / 8;
  localparam int IW    = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(BYTES - 1);

  eng_state_e        state;
  logic [BAUD_W-1:0] cnt, baud_q;
  logic              sclk_q, mosi_q, cs_n_q;
  logic              rd_phase, mode_q;
  logic [CNT_W-1:0]  rcnt_q, left;
  logic [2:0]        bitn;
  logic [7:0]        tx_sh, rx_sh, cur_byte;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [IW-1:0]     tx_idx, rx_idx;
  logic              tick;

  assign tick     = (cnt == baud_q);
  assign cur_byte = (tx_idx == '0) ? tx_data[7:0] : tx_word[{tx_idx, 3'b000} +: 8];
  assign tx_pop   = (state == ES_FETCH) && !rd_phase && (tx_idx == '0) && !tx_empty;
  assign rx_push  = (state == ES_PUSH) && !rx_full;
  assign rx_data  = rx_word;
  assign busy     = (state != ES_IDLE);
  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
  assign cs_n     = cs_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ES_IDLE;
      cnt      <= '0;
      baud_q   <= '0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      rd_phase <= 1'b0;
      mode_q   <= 1'b0;
      rcnt_q   <= '0;
      left     <= '0;
      bitn     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      tx_word  <= '0;
      rx_word  <= '0;
      tx_idx   <= '0;
      rx_idx   <= '0;
    end else begin
      case (state)
        ES_IDLE: begin
          if (start) begin
            baud_q   <= baud;
            mode_q   <= mode_wr;
            rcnt_q   <= rcnt_m1;
            left     <= wcnt_m1;
            rd_phase <= 1'b0;
            tx_idx   <= '0;
            rx_idx   <= '0;
            rx_word  <= '0;
            state    <= ES_FETCH;
          end
        end
        ES_FETCH: begin
          // a write byte waits here until its word has arrived
          if (rd_phase || tx_idx != '0 || !tx_empty) begin
            if (rd_phase) begin
              tx_sh  <= '0;
              mosi_q <= 1'b0;
            end else begin
              tx_sh  <= cur_byte;
              mosi_q <= cur_byte[7];
              tx_idx <= tx_idx + 1'b1;
              if (tx_idx == '0) tx_word <= tx_data;
            end
            cs_n_q <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            state  <= ES_LOW;
          end
        end
        ES_LOW: begin
          if (tick) begin
            cnt    <= '0;
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[6:0], miso};
            state  <= ES_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ES_HIGH: begin
          if (tick) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
            if (bitn != 3'd7) begin
              bitn   <= bitn + 1'b1;
              tx_sh  <= {tx_sh[6:0], 1'b0};
              mosi_q <= tx_sh[6];
              state  <= ES_LOW;
            end else if (rd_phase) begin
              rx_word[{rx_idx, 3'b000} +: 8] <= rx_sh;
              rx_idx <= rx_idx + 1'b1;
              if (rx_idx == IDX_LAST || left == '0) begin
                state <= ES_PUSH;
              end else begin
                left  <= left - 1'b1;
                state <= ES_FETCH;
              end
            end else if (left != '0) begin
              left  <= left - 1'b1;
              state <= ES_FETCH;
            end else if (mode_q) begin
              rd_phase <= 1'b1;
              left     <= rcnt_q;
              state    <= ES_FETCH;
            end else begin
              state <= ES_TRAIL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ES_PUSH: begin
          // clock is held low until the receive queue has room
          if (!rx_full) begin
            rx_word <= '0;
            if (left != '0) begin
              left  <= left - 1'b1;
              state <= ES_FETCH;
            end else begin
              cnt   <= '0;
              state <= ES_TRAIL;
            end
          end
        end
        ES_TRAIL: begin
          if (tick) begin
            cnt    <= '0;
            cs_n_q <= 1'b1;
            state  <= ES_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ES_IDLE;
      endcase
    end
  end

  // R9: no clock activity while deselected
  assert_sclk_low_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sclk_q);
  // R7: MOSI stays low while reading
  assert_read_mosi_low_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_phase && (state == ES_LOW || state == ES_HIGH)) |-> !mosi_q);
  // R1: a high half is not cut short before the divider expires
  assert_high_half_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ES_HIGH && !tick) |=> (sclk_q && state == ES_HIGH));
  // R3: a trigger seen while idle makes the engine busy
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ES_IDLE && start) |=> busy);
endmodule

// File: rtl/spi_wr_master.sv
module spi_wr_master
  import spi_wr_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 8,   // at most 8 so the descriptor fields do not overlap
  parameter int BAUD_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int WORD_W   = 32;
  localparam int DIV_HI_W = WORD_W - BAUD_W;

  logic                soft_rst_q, core_rst;
  logic [BAUD_W-1:0]   baud_q;
  logic [DIV_HI_W-1:0] div_hi_q;
  logic [WORD_W-1:0]   ien_q;
  logic                mode_q, start_q;
  logic [CNT_W-1:0]    wcnt_q, rcnt_q;
  logic                eng_busy, busy_any;
  logic                tx_full, tx_empty, tx_pop, tx_push;
  logic                rx_full, rx_empty, rx_pop, rx_push;
  logic [WORD_W-1:0]   tx_head, rx_head, rx_word;
  logic                wr_ctrl, wr_div, wr_desc, wr_ien, wr_data, rd_data;
  logic [WORD_W-1:0]   stat_word, desc_word;

  assign wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
  assign wr_div   = bus_wr && (bus_addr == RA_DIV);
  assign wr_desc  = bus_wr && (bus_addr == RA_DESC);
  assign wr_ien   = bus_wr && (bus_addr == RA_IEN);
  assign wr_data  = bus_wr && (bus_addr == RA_DATA);
  assign rd_data  = bus_rd && (bus_addr == RA_DATA);

  assign core_rst = rst || soft_rst_q;
  assign busy_any = eng_busy || start_q;
  assign tx_push  = wr_data && !tx_full;
  assign rx_pop   = rd_data && !rx_empty;

  always_comb begin
    stat_word = '0;
    stat_word[STAT_BUSY]    = busy_any;
    stat_word[STAT_TXFULL]  = tx_full;
    stat_word[STAT_RXAVAIL] = !rx_empty;
    desc_word = '0;
    desc_word[DESC_MODE_BIT]              = mode_q;
    desc_word[DESC_WCNT_LSB +: CNT_W]     = wcnt_q;
    desc_word[DESC_RCNT_LSB +: CNT_W]     = rcnt_q;
    desc_word[DESC_GO_BIT]                = busy_any;
  end

  // settings that survive the control-register reset
  always_ff @(posedge clk) begin
    if (rst) begin
      soft_rst_q <= 1'b0;
      baud_q     <= '0;
      div_hi_q   <= '0;
      ien_q      <= '0;
    end else begin
      soft_rst_q <= wr_ctrl && bus_wdata[0];
      if (wr_div) {div_hi_q, baud_q} <= bus_wdata;
      if (wr_ien) ien_q <= bus_wdata;
    end
  end

  // descriptor and trigger, cleared by either reset
  always_ff @(posedge clk) begin
    if (core_rst) begin
      mode_q  <= 1'b0;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_desc && bus_wdata[DESC_GO_BIT] && !busy_any;
      if (wr_desc && !busy_any) begin
        mode_q <= bus_wdata[DESC_MODE_BIT];
        wcnt_q <= bus_wdata[DESC_WCNT_LSB +: CNT_W];
        rcnt_q <= bus_wdata[DESC_RCNT_LSB +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RA_DIV:  bus_rdata <= {div_hi_q, baud_q};
        RA_DESC: bus_rdata <= desc_word;
        RA_STAT: bus_rdata <= stat_word;
        RA_IEN:  bus_rdata <= ien_q;
        RA_DATA: bus_rdata <= rx_empty ? '0 : rx_head;
        default: bus_rdata <= '0;
      endcase
    end
  end

  spi_wr_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst(core_rst), .push(tx_push), .wdata(bus_wdata),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  spi_wr_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst(core_rst), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
  );

  spi_wr_engine #(.CNT_W(CNT_W), .BAUD_W(BAUD_W), .WORD_W(WORD_W)) u_engine (
    .clk(clk), .rst(core_rst), .start(start_q), .mode_wr(mode_q),
    .wcnt_m1(wcnt_q), .rcnt_m1(rcnt_q), .baud(baud_q),
    .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_word),
    .busy(eng_busy), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .miso(spi_miso)
  );

  // R3: the descriptor is frozen while a transaction runs
  assert_desc_locked_R3: assert property (@(posedge clk) disable iff (core_rst)
    (busy_any && wr_desc) |=> ($stable(wcnt_q) && $stable(rcnt_q) && $stable(mode_q)));
  // R10: a control reset leaves the select released
  assert_soft_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst_q |=> (spi_cs_n && !busy_any));
endmodule

// File: tb/tb_spi_wr_master.sv
module tb_spi_wr_master;
  import spi_wr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  always #5 clk = ~clk;

  spi_wr_master dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] tx_b [64];
  logic [7:0] resp_b [64];
  logic [7:0] mon_b [64];
  logic [7:0] sh;
  int mon_n, nb, bitpos, cs_falls, cur_baud;
  int hi_cnt, width_err, lead_cnt, lead_done, trail_cnt, last_trail;

  // slave model: streams resp_b MSB first from select fall, captures MOSI
  assign spi_miso = (bitpos < 512) ? resp_b[bitpos / 8][7 - (bitpos % 8)] : 1'b0;

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    nb++;
    if (nb == 8) begin
      if (mon_n < 64) mon_b[mon_n] = sh;
      mon_n++;
      nb = 0;
    end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) bitpos++;
  always @(negedge spi_cs_n) cs_falls++;
  always @(posedge spi_cs_n) last_trail = trail_cnt;

  always @(posedge clk) begin
    if (spi_sclk) begin
      hi_cnt++;
      trail_cnt = 0;
      lead_done = 1;
    end else begin
      if (hi_cnt != 0) begin
        if (hi_cnt != cur_baud + 1) width_err++;
        hi_cnt = 0;
      end
      if (!spi_cs_n) begin
        trail_cnt++;
        if (lead_done == 0) lead_cnt++;
      end
    end
  end

  task automatic clear_mon();
    mon_n = 0; nb = 0; bitpos = 0; cs_falls = 0; sh = '0;
    hi_cnt = 0; width_err = 0; lead_cnt = 0; lead_done = 0;
    trail_cnt = 0; last_trail = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_tx_word(input int w, input int wlen);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (w * 4 + k < wlen) r[k*8 +: 8] = tx_b[w * 4 + k];
    return r;
  endfunction

  function automatic logic [31:0] exp_rx_word(input int w, input int wlen, input int rlen);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (w * 4 + k < rlen) r[k*8 +: 8] = resp_b[wlen + w * 4 + k];
    return r;
  endfunction

  task automatic wait_idle();
    logic [31:0] st;
    do reg_read(RA_STAT, st); while (st[0]);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_xfer(input bit wr_mode, input int wlen, input int rlen, input int baud);
    logic [31:0] st, d, desc;
    int nw, rw, got, bad_tx, bad_rd;
    clear_mon();
    cur_baud = baud;
    reg_write(RA_DIV, {24'hA5C35A, 8'(baud)});
    for (int i = 0; i < 64; i++) begin
      tx_b[i]   = 8'($urandom);
      resp_b[i] = 8'($urandom);
    end
    desc = {8'h00, 8'(wr_mode ? rlen - 1 : 0), 8'(wlen - 1), 7'b0, wr_mode};
    reg_write(RA_DESC, desc);
    nw = (wlen + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      do reg_read(RA_STAT, st); while (st[1]);
      reg_write(RA_DATA, exp_tx_word(w, wlen));
      if (w == 0) begin
        reg_write(RA_DESC, desc | 32'h8000_0000);
        reg_read(RA_STAT, st);
        check(st[0] == 1'b1, "R3", "busy after trigger", st, 32'h1);
      end
    end
    rw = wr_mode ? (rlen + 3) / 4 : 0;
    got = 0;
    while (got < rw) begin
      reg_read(RA_STAT, st);
      if (st[2]) begin
        reg_read(RA_DATA, d);
        check(d === exp_rx_word(got, wlen, rlen), "R6", "received word", d,
              exp_rx_word(got, wlen, rlen));
        got++;
      end
    end
    wait_idle();
    check(mon_n == wlen + (wr_mode ? rlen : 0), "R2", "bytes clocked",
          32'(mon_n), 32'(wlen + (wr_mode ? rlen : 0)));
    check(cs_falls == 1, "R2", "select pulses", 32'(cs_falls), 32'd1);
    bad_tx = 0;
    for (int i = 0; i < wlen; i++) if (mon_b[i] !== tx_b[i]) bad_tx++;
    check(bad_tx == 0, "R5", "write bytes on MOSI mismatched", 32'(bad_tx), 32'd0);
    bad_rd = 0;
    if (wr_mode) for (int i = wlen; i < wlen + rlen; i++) if (mon_b[i] !== 8'h00) bad_rd++;
    check(bad_rd == 0, "R7", "nonzero MOSI bytes in read phase", 32'(bad_rd), 32'd0);
    check(width_err == 0, "R1", "SCLK high halves of wrong width", 32'(width_err), 32'd0);
    check(lead_cnt == baud + 1, "R9", "select lead cycles", 32'(lead_cnt), 32'(baud + 1));
    check(last_trail >= baud + 1, "R9", "select trail cycles", 32'(last_trail), 32'(baud + 1));
    reg_read(RA_STAT, st);
    check(st == 32'h0, "R8", "status after drained transfer", st, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, st;
    void'($urandom(32'h5EED_1234));
    clear_mon();
    cur_baud = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R11", "pins after reset",
          {29'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'h4);
    reg_read(RA_STAT, d); check(d == 0, "R11", "status after reset", d, 0);
    reg_read(RA_IEN, d);  check(d == 0, "R11", "interrupt enable after reset", d, 0);
    reg_read(RA_DESC, d); check(d == 0, "R11", "descriptor after reset", d, 0);
    reg_read(RA_DATA, d); check(d == 0, "R8", "empty data read", d, 0);
    reg_read(RA_STAT, d); check(d[2] == 1'b0, "R8", "rx available after empty read", d, 0);
    reg_write(RA_IEN, 32'h1357_9BDF);
    reg_read(RA_IEN, d);  check(d == 32'h1357_9BDF, "R11", "interrupt enable readback", d, 32'h1357_9BDF);
    reg_write(RA_DIV, 32'hABCD_EF05);
    reg_read(RA_DIV, d);  check(d == 32'hABCD_EF05, "R1", "divisor readback", d, 32'hABCD_EF05);

    // directed transfers
    run_xfer(1'b0, 1, 1, 0);
    run_xfer(1'b1, 1, 1, 0);
    run_xfer(1'b1, 3, 20, 1);
    run_xfer(1'b1, 4, 5, 2);

    // R4: queue fills at four words, fifth dropped
    clear_mon();
    cur_baud = 1;
    reg_write(RA_DIV, 32'h1);
    for (int i = 0; i < 20; i++) tx_b[i] = 8'($urandom);
    reg_write(RA_DESC, {16'h0, 8'd15, 8'h00});
    for (int w = 0; w < 5; w++) reg_write(RA_DATA, exp_tx_word(w, 20));
    reg_read(RA_STAT, st);
    check(st[1] == 1'b1, "R4", "tx full after four words", st, 32'h2);
    reg_write(RA_DESC, 32'h8000_0F00);
    wait_idle();
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) if (mon_b[i] !== tx_b[i]) bad++;
      check(mon_n == 16 && bad == 0, "R4", "bytes of queued words", 32'(bad), 32'd0);
    end
    run_xfer(1'b0, 4, 1, 1); // a dropped fifth word would appear here

    // R3: descriptor write while busy ignored
    clear_mon();
    cur_baud = 3;
    reg_write(RA_DIV, 32'h3);
    reg_write(RA_DESC, 32'h0000_0300);
    reg_write(RA_DATA, 32'h8421_C3A5);
    reg_write(RA_DESC, 32'h8000_0300);
    reg_write(RA_DESC, 32'h8005_0701);
    wait_idle();
    check(mon_n == 4, "R3", "bytes after ignored descriptor", 32'(mon_n), 32'd4);
    reg_read(RA_DESC, d);
    check(d == 32'h0000_0300, "R3", "descriptor readback", d, 32'h0000_0300);

    // R10: control reset aborts a running transfer
    clear_mon();
    cur_baud = 10;
    reg_write(RA_DIV, 32'h0000_770A);
    reg_write(RA_DESC, 32'h0003_0301);
    reg_write(RA_DATA, 32'h1122_3344);
    reg_write(RA_DATA, 32'h5566_7788);
    reg_write(RA_DESC, 32'h8003_0301);
    repeat (60) @(negedge clk);
    check(spi_cs_n == 1'b0, "R10", "select low before abort", {31'b0, spi_cs_n}, 32'h0);
    reg_write(RA_CTRL, 32'h1);
    repeat (2) @(negedge clk);
    check(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R10", "pins after abort",
          {30'b0, spi_cs_n, spi_sclk}, 32'h2);
    reg_read(RA_STAT, d); check(d == 0, "R10", "status after abort", d, 0);
    reg_read(RA_DATA, d); check(d == 0, "R10", "data after abort", d, 0);
    reg_read(RA_DIV, d);  check(d == 32'h0000_770A, "R10", "divisor kept", d, 32'h0000_770A);
    reg_read(RA_IEN, d);  check(d == 32'h1357_9BDF, "R10", "interrupt enable kept", d, 32'h1357_9BDF);

    // constrained random transfers
    for (int t = 0; t < 10; t++)
      run_xfer(1'($urandom % 2), 1 + int'($urandom % 12), 1 + int'($urandom % 12),
               int'($urandom % 4));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule